// File: doc/BRIEF.md
# Pipeline Forwarding and Load-Use Stall Unit

This block is the hazard controller for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Both memories are synchronous, so a loaded word first appears in the writeback stage. Branches are compared in decode and have one delay slot that always executes. As a result, no flush logic exists. The unit compares the decode-stage source register numbers with the destination register numbers of the three later stages. From that it produces bypass selects for the two execute operands and for the two inputs of the decode-stage branch comparator.

The execute selects are worked out one cycle early, while the consumer is still in decode, and held in a register. The datapath receives them straight from flops in the cycle the consumer executes.

A single `stall` output holds the PC and the fetch/decode register and turns the decode/execute register into a bubble. It is raised in three cases: a load followed at once by a reader of its result, a branch whose operands are not yet available, or an external halt request.

Top module: `hazard_unit`

## Requirements
- R1: When the instruction in execute writes a nonzero register that the decode instruction reads, the select for that operand reads 2'b01 (memory-stage result) in the following cycle, if no stall occurs.
- R2: When only the instruction in memory writes the read register, the select for that operand reads 2'b10 (writeback result) in the following cycle.
- R3: When both execute and memory stages write the same read register, the younger producer wins and the select is 2'b01.
- R4: Register 0 is never forwarded: a source or destination number of 0 always gives select 2'b00 (register file).
- R5: A load in execute whose destination is read by the decode instruction raises `stall` for exactly that cycle. Once the load has moved to memory, the stall drops and the consumer's execute select becomes 2'b10.
- R6: In the cycle after a stall, both execute selects are 2'b00, because a bubble carries no sources.
- R7: A source whose use flag is low neither forwards nor stalls.
- R8: For a branch in decode, the comparator select is 2'b01 for a matching non-load result in memory, 2'b10 for a matching writeback result, and 2'b00 otherwise.
- R9: A branch in decode stalls while a matching producer sits in execute (any kind) or a matching load sits in memory.
- R10: `brk_hold` high raises `stall` in the same cycle, regardless of the other inputs.
- R11: After reset, both execute selects are 2'b00, and no select ever takes the value 2'b11.
- R12: A stage whose write-enable is low never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| id_rs | input | 5 | Decode first source register number |
| id_rt | input | 5 | Decode second source register number |
| id_use_rs | input | 1 | Decode instruction reads first source |
| id_use_rt | input | 1 | Decode instruction reads second source |
| id_branch | input | 1 | Decode instruction is a compare-in-decode branch |
| brk_hold | input | 1 | External halt request |
| ex_dst | input | 5 | Execute-stage destination register |
| ex_wr | input | 1 | Execute-stage writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | 5 | Memory-stage destination register |
| mem_wr | input | 1 | Memory-stage writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | 5 | Writeback-stage destination register |
| wb_wr | input | 1 | Writeback-stage writes a register |
| stall | output | 1 | Hold PC and fetch/decode register, bubble decode/execute |
| ex_fwd_a | output | 2 | Registered execute select, first operand |
| ex_fwd_b | output | 2 | Registered execute select, second operand |
| br_fwd_a | output | 2 | Branch comparator select, first operand |
| br_fwd_b | output | 2 | Branch comparator select, second operand |

## Verification
The hardest case to reach from the ports is a stall cycle in which a bubble must override a forwarding match that would otherwise be captured. The stimulus creates this on purpose. It puts a load in execute that feeds the second source, and in the same cycle puts a plain memory-stage writer of the first source. Without the bubble, the first select would register as 2'b10. The bench then advances the load to memory and checks that the stall releases after one cycle and that the consumer picks up the writeback path.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int REG_W = 5;
  localparam int N_OPS = 2;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick #(
  parameter int W = 5
) (
  input  logic [W-1:0] src,
  input  logic         use_src,
  input  logic [W-1:0] young_dst,
  input  logic         young_wr,
  input  logic [W-1:0] old_dst,
  input  logic         old_wr,
  output logic [1:0]   sel,
  output logic         young_hit,
  output logic         old_hit
);
  import hz_pkg::*;

  logic src_live;

  always_comb begin
    src_live  = use_src && (src != '0);
    young_hit = src_live && young_wr && (young_dst == src);
    old_hit   = src_live && old_wr && (old_dst == src);
    if (young_hit)    sel = FWD_MEM;
    else if (old_hit) sel = FWD_WB;
    else              sel = FWD_RF;
  end
endmodule

// File: rtl/hz_stall.sv
module hz_stall #(
  parameter int N = 2
) (
  input  logic         id_branch,
  input  logic         ex_load,
  input  logic         mem_load,
  input  logic         brk_hold,
  input  logic [N-1:0] ex_hit,
  input  logic [N-1:0] mem_hit,
  output logic         stall
);
  logic load_use;
  logic br_wait;

  always_comb begin
    load_use = ex_load && (|ex_hit);
    br_wait  = id_branch && ((|ex_hit) || (mem_load && (|mem_hit)));
    stall    = load_use || br_wait || brk_hold;
  end
endmodule

// File: rtl/hz_exsel_reg.sv
module hz_exsel_reg #(
  parameter int N = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bubble,
  input  logic [N-1:0][1:0] sel_d,
  output logic [N-1:0][1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (rst || bubble) sel_q <= '0;
    else               sel_q <= sel_d;
  end

  assert_bubble_clears_R6: assert property (@(posedge clk) disable iff (rst)
    bubble |=> (sel_q == '0));

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_no_code3_R11: assert property (@(posedge clk) disable iff (rst)
      sel_q[i] != 2'b11);
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int REG_W = hz_pkg::REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_use_rs,
  input  logic             id_use_rt,
  input  logic             id_branch,
  input  logic             brk_hold,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  input  logic             mem_load,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  output logic             stall,
  output logic [1:0]       ex_fwd_a,
  output logic [1:0]       ex_fwd_b,
  output logic [1:0]       br_fwd_a,
  output logic [1:0]       br_fwd_b
);
  import hz_pkg::*;
  localparam int N = N_OPS;

  logic [N-1:0][REG_W-1:0] src;
  logic [N-1:0]            use_src;
  logic [N-1:0][1:0]       ex_sel_d, ex_sel_q, br_sel;
  logic [N-1:0]            ex_hit, mem_hit_ex, mem_hit_br, wb_hit;

  assign src     = {id_rt, id_rs};
  assign use_src = {id_use_rt, id_use_rs};

  for (genvar i = 0; i < N; i++) begin : g_op
    // early pick for execute: producer now in EX reaches MEM next cycle
    hz_fwd_pick #(.W(REG_W)) u_ex_pick (
      .src(src[i]), .use_src(use_src[i]),
      .young_dst(ex_dst), .young_wr(ex_wr),
      .old_dst(mem_dst), .old_wr(mem_wr),
      .sel(ex_sel_d[i]), .young_hit(ex_hit[i]), .old_hit(mem_hit_ex[i])
    );
    // branch comparator pick in decode: sources now in MEM and WB
    hz_fwd_pick #(.W(REG_W)) u_br_pick (
      .src(src[i]), .use_src(use_src[i]),
      .young_dst(mem_dst), .young_wr(mem_wr),
      .old_dst(wb_dst), .old_wr(wb_wr),
      .sel(br_sel[i]), .young_hit(mem_hit_br[i]), .old_hit(wb_hit[i])
    );
  end

  hz_stall #(.N(N)) u_stall (
    .id_branch(id_branch), .ex_load(ex_load), .mem_load(mem_load),
    .brk_hold(brk_hold), .ex_hit(ex_hit), .mem_hit(mem_hit_br),
    .stall(stall)
  );

  hz_exsel_reg #(.N(N)) u_exsel (
    .clk(clk), .rst(rst), .bubble(stall),
    .sel_d(ex_sel_d), .sel_q(ex_sel_q)
  );

  assign ex_fwd_a = ex_sel_q[0];
  assign ex_fwd_b = ex_sel_q[1];
  assign br_fwd_a = id_branch ? br_sel[0] : FWD_RF;
  assign br_fwd_b = id_branch ? br_sel[1] : FWD_RF;

  assert_zero_never_fwd_R4: assert property (@(posedge clk) disable iff (rst)
    (id_rs == '0) |=> (ex_fwd_a == FWD_RF));

  assert_brk_stalls_R10: assert property (@(posedge clk) disable iff (rst)
    brk_hold |-> stall);

  assert_br_load_waits_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_load && (br_fwd_a == FWD_MEM || br_fwd_b == FWD_MEM)) |-> stall);

  assert_br_sel_legal_R11: assert property (@(posedge clk) disable iff (rst)
    (br_fwd_a != 2'b11) && (br_fwd_b != 2'b11));
endmodule

// File: tb/hazard_unit_bench.sv
module hazard_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic [4:0] id_rs, id_rt, ex_dst, mem_dst, wb_dst;
  logic id_use_rs, id_use_rt, id_branch, brk_hold;
  logic ex_wr, ex_load, mem_wr, mem_load, wb_wr;
  logic stall;
  logic [1:0] ex_fwd_a, ex_fwd_b, br_fwd_a, br_fwd_b;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_unit u_hazard_unit (
    .clk(clk), .rst(rst), .id_rs(id_rs), .id_rt(id_rt),
    .id_use_rs(id_use_rs), .id_use_rt(id_use_rt), .id_branch(id_branch),
    .brk_hold(brk_hold), .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load),
    .wb_dst(wb_dst), .wb_wr(wb_wr), .stall(stall),
    .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b),
    .br_fwd_a(br_fwd_a), .br_fwd_b(br_fwd_b)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic quiet();
    id_rs = 0; id_rt = 0; id_use_rs = 0; id_use_rt = 0; id_branch = 0;
    brk_hold = 0; ex_dst = 0; ex_wr = 0; ex_load = 0;
    mem_dst = 0; mem_wr = 0; mem_load = 0; wb_dst = 0; wb_wr = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    quiet();
    id_rs = 3; id_use_rs = 1; ex_dst = 3; ex_wr = 1;
    repeat (3) tick();
    chk("R11 reset sel a", ex_fwd_a, 0);
    chk("R11 reset sel b", ex_fwd_b, 0);
    @(negedge clk); rst = 0; quiet();
    tick();
  endtask

  task automatic t_mem_fwd();
    @(negedge clk); quiet();
    id_rs = 3; id_use_rs = 1; id_rt = 4; id_use_rt = 1; ex_dst = 3; ex_wr = 1;
    #1 chk("R1 no stall", stall, 0);
    tick();
    chk("R1 sel a mem", ex_fwd_a, 1);
    chk("R1 sel b rf", ex_fwd_b, 0);
  endtask

  task automatic t_wb_fwd();
    @(negedge clk); quiet();
    id_rt = 4; id_use_rt = 1; mem_dst = 4; mem_wr = 1;
    tick();
    chk("R2 sel b wb", ex_fwd_b, 2);
  endtask

  task automatic t_priority();
    @(negedge clk); quiet();
    id_rs = 5; id_use_rs = 1; ex_dst = 5; ex_wr = 1; mem_dst = 5; mem_wr = 1;
    tick();
    chk("R3 younger wins", ex_fwd_a, 1);
  endtask

  task automatic t_zero();
    @(negedge clk); quiet();
    id_rs = 0; id_use_rs = 1; id_branch = 1; ex_dst = 0; ex_wr = 1; ex_load = 1;
    mem_dst = 0; mem_wr = 1;
    #1 chk("R4 zero no stall", stall, 0);
    chk("R4 zero br sel", br_fwd_a, 0);
    tick();
    chk("R4 zero ex sel", ex_fwd_a, 0);
  endtask

  task automatic t_wen();
    @(negedge clk); quiet();
    id_rs = 6; id_use_rs = 1; ex_dst = 6; ex_wr = 0; mem_dst = 6; mem_wr = 0;
    tick();
    chk("R12 no write no match", ex_fwd_a, 0);
  endtask

  task automatic t_use();
    @(negedge clk); quiet();
    id_rt = 8; id_use_rt = 0; ex_dst = 8; ex_wr = 1; ex_load = 1;
    #1 chk("R7 unused no stall", stall, 0);
    tick();
    chk("R7 unused no fwd", ex_fwd_b, 0);
  endtask

  task automatic t_load_use();
    @(negedge clk); quiet();
    id_rt = 7; id_use_rt = 1; ex_dst = 7; ex_wr = 1; ex_load = 1;
    id_rs = 9; id_use_rs = 1; mem_dst = 9; mem_wr = 1;
    #1 chk("R5 load-use stall", stall, 1);
    tick();
    chk("R6 bubble sel a", ex_fwd_a, 0);
    chk("R6 bubble sel b", ex_fwd_b, 0);
    @(negedge clk); quiet();
    id_rt = 7; id_use_rt = 1; mem_dst = 7; mem_wr = 1; mem_load = 1;
    #1 chk("R5 stall one cycle", stall, 0);
    tick();
    chk("R5 load via wb", ex_fwd_b, 2);
  endtask

  task automatic t_branch_fwd();
    @(negedge clk); quiet();
    id_branch = 1; id_rs = 2; id_use_rs = 1; id_rt = 3; id_use_rt = 1;
    mem_dst = 2; mem_wr = 1; wb_dst = 3; wb_wr = 1;
    #1 chk("R8 br a mem", br_fwd_a, 1);
    chk("R8 br b wb", br_fwd_b, 2);
    chk("R8 br no stall", stall, 0);
    @(negedge clk); mem_dst = 11; wb_dst = 12;
    #1 chk("R8 br a rf", br_fwd_a, 0);
    chk("R8 br b rf", br_fwd_b, 0);
  endtask

  task automatic t_branch_stall();
    @(negedge clk); quiet();
    id_branch = 1; id_rs = 2; id_use_rs = 1; id_rt = 3; id_use_rt = 1;
    ex_dst = 2; ex_wr = 1;
    #1 chk("R9 br on ex alu", stall, 1);
    @(negedge clk); quiet();
    id_branch = 1; id_rs = 2; id_use_rs = 1; id_rt = 3; id_use_rt = 1;
    mem_dst = 3; mem_wr = 1; mem_load = 1;
    #1 chk("R9 br on mem load", stall, 1);
    @(negedge clk); mem_load = 0;
    #1 chk("R9 br mem alu ok", stall, 0);
    chk("R9 br mem alu sel", br_fwd_b, 1);
  endtask

  task automatic t_break();
    @(negedge clk); quiet();
    id_rs = 4; id_use_rs = 1; ex_dst = 4; ex_wr = 1; brk_hold = 1;
    #1 chk("R10 halt stalls", stall, 1);
    tick();
    chk("R10 halt bubble", ex_fwd_a, 0);
    @(negedge clk); brk_hold = 0;
    #1 chk("R10 release", stall, 0);
  endtask

  initial begin
    quiet();
    t_reset();
    t_mem_fwd();
    t_wb_fwd();
    t_priority();
    t_zero();
    t_wen();
    t_use();
    t_load_use();
    t_branch_fwd();
    t_branch_stall();
    t_break();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule